// File: doc/BRIEF.md
# IN Endpoint Transmit Bank Manager

This block tracks the transmit banks of a single device-side IN endpoint. Firmware fills a bank elsewhere and then strobes a packet-ready write; the block counts the banks that hold a packet and have not yet gone out. The bus engine reports three events: an IN token that begins sending the oldest queued bank, the end of sending that packet, and the host handshake for it. The endpoint type selects which event retires a bank. An isochronous endpoint retires a bank when the packet has been sent. A control, bulk or interrupt endpoint retires it only when the host acknowledges it.

Firmware can ask for a queued bank to be dropped with a kill strobe. The request is held in a kill-pending flag and resolved on the following cycles. A request on an empty endpoint drops nothing. A request that meets a transfer of the only queued bank is refused: that bank is sent, and the flag clears once it has gone. With two or more banks queued during a transfer, the newest bank is dropped and the transfer goes on. The block also keeps a sticky transmit-complete flag, a sticky error for a packet-ready write into a full endpoint, and a one-cycle interrupt request.

Top module: `in_bank_mgr`

## Requirements
- R1: `ept_reset` or `ept_disable` clears the busy count, the transfer in progress, `tx_complete`, `kill_pending`, `ovf_err` and `irq` on the next clock edge. The same clearing applies after `rst_n` is released.
- R2: Each `fw_pkt_ready` strobe raises `busy_banks` by one. `pkt_ready_sts` reads 1 only when `busy_banks` equals NUM_BANKS, so it reads 0 after a write that still leaves a bank free.
- R3: A `fw_pkt_ready` strobe while all NUM_BANKS banks are busy leaves `busy_banks` unchanged and sets `ovf_err`. `ovf_err` stays set until R1 clears it.
- R4: With `iso_mode`=0, a bank is retired (`busy_banks` minus one) only by `bus_host_ack` after a `bus_in_token` has started a transfer. `bus_pkt_sent` alone changes nothing.
- R5: With `iso_mode`=1, `bus_pkt_sent` during a started transfer retires the bank.
- R6: Retiring a bank sets `tx_complete`. The flag stays set until a `fw_txc_clr` strobe or R1 clears it.
- R7: A `fw_kill` sets `kill_pending` on the next edge. If no transfer is in progress or starting on the following cycle, the newest bank is dropped on that following edge and `kill_pending` clears.
- R8: If the pending kill meets a transfer with exactly one bank busy, nothing is dropped. `kill_pending` stays 1 until the bank is retired and clears one cycle after the retire. `fw_kill` strobes made while pending are ignored.
- R9: If the pending kill meets a transfer with two or more banks busy, the newest bank is dropped and `kill_pending` clears. The bank being sent still retires normally.
- R10: A pending kill with `busy_banks` = 0 clears `kill_pending` on the next edge and changes no count.
- R11: `irq` pulses for exactly one cycle, one edge after `pkt_ready_sts` falls because of a retire or a drop, and only if `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_mode | input | 1 | 1: isochronous retire rule; 0: handshake retire rule |
| int_en | input | 1 | Interrupt enable for the packet-ready clear |
| fw_pkt_ready | input | 1 | Firmware strobe: one more bank filled |
| fw_kill | input | 1 | Firmware strobe: drop a queued bank |
| fw_txc_clr | input | 1 | Firmware write-one-to-clear of tx_complete |
| ept_reset | input | 1 | Endpoint reset strobe |
| ept_disable | input | 1 | Endpoint disable strobe |
| bus_in_token | input | 1 | IN token starts sending the oldest bank |
| bus_pkt_sent | input | 1 | Packet of the current transfer sent |
| bus_host_ack | input | 1 | Host acknowledged the current packet |
| busy_banks | output | CNT_W | Number of banks holding unsent packets |
| pkt_ready_sts | output | 1 | All banks busy |
| tx_complete | output | 1 | Sticky transmit-complete flag |
| kill_pending | output | 1 | Kill request not yet resolved |
| ovf_err | output | 1 | Sticky packet-ready-while-full error |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that the bus engine sends `bus_pkt_sent` and `bus_host_ack` only after its own IN token and only one at a time. They also assume that the strobes are single-cycle pulses and that endpoint reset and disable are not held over a cycle in which a result is checked. The directed tasks raise each strobe for exactly one cycle and always start a transfer with a token before any sent or acknowledge event. They reach the arbitration corners by placing the IN token on the very cycle in which a pending kill is resolved.

// File: rtl/inbm_pkg.sv
package inbm_pkg;

   // outcome of evaluating a pending kill request in one cycle
   typedef enum logic [1:0] {
      KD_IDLE  = 2'd0,
      KD_HOLD  = 2'd1,
      KD_EMPTY = 2'd2,
      KD_DROP  = 2'd3
   } kill_dec_t;

   localparam int unsigned MAX_BANKS = 3;

endpackage

// File: rtl/inbm_bank_count.sv
module inbm_bank_count #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fill_req,
   input  logic [1:0]       dec_n,
   output logic [CNT_W-1:0] busy_q,
   output logic             full,
   output logic             ovf_q
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_BANKS);

   logic             fill_ok;
   logic [CNT_W:0]   nxt_wide;

   assign full     = (busy_q == FULL_CNT);
   assign fill_ok  = fill_req && !full;
   assign nxt_wide = {1'b0, busy_q} + {{CNT_W{1'b0}}, fill_ok} - (CNT_W + 1)'(dec_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         ovf_q  <= 1'b0;
      end else if (clr) begin
         busy_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         busy_q <= nxt_wide[CNT_W-1:0];
         if (fill_req && full)
            ovf_q <= 1'b1;
      end
   end

   a_r2_no_exceed: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q <= FULL_CNT);

   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> ({1'b0, busy_q} >= (CNT_W + 1)'(dec_n)));

   a_r3_full_fill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && fill_req && full && dec_n == 2'd0) |=> (full && ovf_q));

   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr) |=> ovf_q);

   a_r1_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (busy_q == '0 && !ovf_q));

endmodule

// File: rtl/inbm_xfer.sv
module inbm_xfer (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic iso_mode,
   input  logic have_bank,
   input  logic in_token,
   input  logic pkt_sent,
   input  logic host_ack,
   input  logic txc_clr,
   output logic in_flight_q,
   output logic token_take,
   output logic retire,
   output logic txc_q
);

   logic done_evt;

   // the retire event depends on the endpoint type
   assign done_evt   = iso_mode ? pkt_sent : host_ack;
   assign retire     = in_flight_q && done_evt && !clr;
   assign token_take = in_token && have_bank && !in_flight_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_flight_q <= 1'b0;
         txc_q       <= 1'b0;
      end else if (clr) begin
         in_flight_q <= 1'b0;
         txc_q       <= 1'b0;
      end else begin
         if (token_take)
            in_flight_q <= 1'b1;
         else if (retire)
            in_flight_q <= 1'b0;
         if (retire)
            txc_q <= 1'b1;
         else if (txc_clr)
            txc_q <= 1'b0;
      end
   end

   a_r4_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_flight_q && !txc_q) |=> !txc_q);

   a_r4_sent_not_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (!iso_mode && in_flight_q && pkt_sent && !host_ack && !clr) |=> in_flight_q);

   a_r5_iso_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_mode && in_flight_q && pkt_sent && !clr) |=> (txc_q && !in_flight_q));

   a_r6_txc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_q && !txc_clr && !clr) |=> txc_q);

   a_r1_xfer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!txc_q && !in_flight_q));

endmodule

// File: rtl/inbm_kill.sv
module inbm_kill
   import inbm_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             kill_req,
   input  logic [CNT_W-1:0] busy_q,
   input  logic             in_flight_q,
   input  logic             token_take,
   output logic             pending_q,
   output logic             discard
);

   logic      xfer_active;
   logic      have_bank;
   logic      can_drop;
   kill_dec_t dec;

   assign xfer_active = in_flight_q || token_take;
   assign have_bank   = (busy_q != '0);

   generate
      if (NUM_BANKS == 1) begin : g_single
         // one bank: a kill meeting a transfer can never be retargeted
         assign can_drop = have_bank && !xfer_active;
      end else begin : g_multi
         // with a second queued bank the newest one may go even mid-transfer
         assign can_drop = have_bank &&
                           (!xfer_active || (busy_q >= CNT_W'(2)));
      end
   endgenerate

   always_comb begin
      if (!pending_q || clr)
         dec = KD_IDLE;
      else if (!have_bank)
         dec = KD_EMPTY;
      else if (can_drop)
         dec = KD_DROP;
      else
         dec = KD_HOLD;
   end

   assign discard = (dec == KD_DROP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending_q <= 1'b0;
      else if (clr)
         pending_q <= 1'b0;
      else begin
         case (dec)
            KD_EMPTY, KD_DROP: pending_q <= 1'b0;
            KD_HOLD:           pending_q <= 1'b1;
            default:           pending_q <= kill_req;
         endcase
      end
   end

   a_r10_empty_resolves: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !have_bank) |=> !pending_q);

   a_r8_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !clr && busy_q == CNT_W'(1) && xfer_active) |-> !discard);

   a_r7_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !clr && have_bank && !xfer_active) |-> discard);

   a_r7_new_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_q && kill_req && !clr) |=> pending_q);

   a_r1_kill_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !pending_q);

endmodule

// File: rtl/in_bank_mgr.sv
module in_bank_mgr #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iso_mode,
   input  logic             int_en,
   input  logic             fw_pkt_ready,
   input  logic             fw_kill,
   input  logic             fw_txc_clr,
   input  logic             ept_reset,
   input  logic             ept_disable,
   input  logic             bus_in_token,
   input  logic             bus_pkt_sent,
   input  logic             bus_host_ack,
   output logic [CNT_W-1:0] busy_banks,
   output logic             pkt_ready_sts,
   output logic             tx_complete,
   output logic             kill_pending,
   output logic             ovf_err,
   output logic             irq
);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > inbm_pkg::MAX_BANKS) begin : g_bad_banks
         $error("in_bank_mgr: NUM_BANKS must lie in 1..%0d", inbm_pkg::MAX_BANKS);
      end
      if (CNT_W < $clog2(NUM_BANKS + 1)) begin : g_bad_width
         $error("in_bank_mgr: CNT_W too narrow for NUM_BANKS");
      end
   endgenerate

   logic             ep_clr;
   logic [CNT_W-1:0] busy_q;
   logic             full;
   logic             in_flight_q;
   logic             token_take;
   logic             retire;
   logic             discard;
   logic [1:0]       dec_n;
   logic             irq_q;

   assign ep_clr = ept_reset || ept_disable;
   assign dec_n  = {1'b0, retire} + {1'b0, discard};

   inbm_bank_count #(
      .NUM_BANKS (NUM_BANKS),
      .CNT_W     (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ep_clr),
      .fill_req (fw_pkt_ready),
      .dec_n    (dec_n),
      .busy_q   (busy_q),
      .full     (full),
      .ovf_q    (ovf_err)
   );

   inbm_xfer u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (ep_clr),
      .iso_mode    (iso_mode),
      .have_bank   (busy_q != '0),
      .in_token    (bus_in_token),
      .pkt_sent    (bus_pkt_sent),
      .host_ack    (bus_host_ack),
      .txc_clr     (fw_txc_clr),
      .in_flight_q (in_flight_q),
      .token_take  (token_take),
      .retire      (retire),
      .txc_q       (tx_complete)
   );

   inbm_kill #(
      .NUM_BANKS (NUM_BANKS),
      .CNT_W     (CNT_W)
   ) u_kill (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (ep_clr),
      .kill_req    (fw_kill),
      .busy_q      (busy_q),
      .in_flight_q (in_flight_q),
      .token_take  (token_take),
      .pending_q   (kill_pending),
      .discard     (discard)
   );

   // interrupt on a hardware-driven fall of the all-busy status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= !ep_clr && int_en && full && (dec_n != 2'd0);
   end

   assign busy_banks    = busy_q;
   assign pkt_ready_sts = full;
   assign irq           = irq_q;

   a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en) |=> !irq);

   a_r11_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!pkt_ready_sts && $past(pkt_ready_sts)));

   a_r1_in_flight_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight_q |-> (busy_q != '0));

endmodule

// File: tb/in_bank_mgr_test.sv
`timescale 1ns/1ps
module in_bank_mgr_test;

   localparam int unsigned NB = 3;
   localparam int unsigned CW = $clog2(NB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iso_mode = 1'b0;
   logic          int_en = 1'b0;
   logic          fw_pkt_ready = 1'b0;
   logic          fw_kill = 1'b0;
   logic          fw_txc_clr = 1'b0;
   logic          ept_reset = 1'b0;
   logic          ept_disable = 1'b0;
   logic          bus_in_token = 1'b0;
   logic          bus_pkt_sent = 1'b0;
   logic          bus_host_ack = 1'b0;
   logic [CW-1:0] busy_banks;
   logic          pkt_ready_sts;
   logic          tx_complete;
   logic          kill_pending;
   logic          ovf_err;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   in_bank_mgr #(.NUM_BANKS(NB)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .iso_mode      (iso_mode),
      .int_en        (int_en),
      .fw_pkt_ready  (fw_pkt_ready),
      .fw_kill       (fw_kill),
      .fw_txc_clr    (fw_txc_clr),
      .ept_reset     (ept_reset),
      .ept_disable   (ept_disable),
      .bus_in_token  (bus_in_token),
      .bus_pkt_sent  (bus_pkt_sent),
      .bus_host_ack  (bus_host_ack),
      .busy_banks    (busy_banks),
      .pkt_ready_sts (pkt_ready_sts),
      .tx_complete   (tx_complete),
      .kill_pending  (kill_pending),
      .ovf_err       (ovf_err),
      .irq           (irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   typedef enum int {P_FILL, P_KILL, P_TXC, P_RST, P_DIS, P_TOK, P_SENT, P_ACK} pulse_t;

   // one-cycle strobe, driven and released at falling edges
   task automatic pulse(input pulse_t which);
      case (which)
         P_FILL: fw_pkt_ready = 1'b1;
         P_KILL: fw_kill      = 1'b1;
         P_TXC:  fw_txc_clr   = 1'b1;
         P_RST:  ept_reset    = 1'b1;
         P_DIS:  ept_disable  = 1'b1;
         P_TOK:  bus_in_token = 1'b1;
         P_SENT: bus_pkt_sent = 1'b1;
         default: bus_host_ack = 1'b1;
      endcase
      tick();
      fw_pkt_ready = 1'b0; fw_kill = 1'b0; fw_txc_clr = 1'b0;
      ept_reset = 1'b0; ept_disable = 1'b0;
      bus_in_token = 1'b0; bus_pkt_sent = 1'b0; bus_host_ack = 1'b0;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset_state();
      chk("R1", "busy after reset", int'(busy_banks), 0);
      chk("R1", "status after reset", int'(pkt_ready_sts), 0);
      chk("R1", "txc after reset", int'(tx_complete), 0);
      chk("R1", "kill pending after reset", int'(kill_pending), 0);
      chk("R1", "ovf after reset", int'(ovf_err), 0);
      chk("R1", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_fill_and_overflow();
      pulse(P_FILL);
      chk("R2", "busy after one fill", int'(busy_banks), 1);
      chk("R2", "status reads clear with free bank", int'(pkt_ready_sts), 0);
      pulse(P_FILL);
      pulse(P_FILL);
      chk("R2", "busy when full", int'(busy_banks), 3);
      chk("R2", "status when full", int'(pkt_ready_sts), 1);
      pulse(P_FILL);
      chk("R3", "busy after fill while full", int'(busy_banks), 3);
      chk("R3", "ovf after fill while full", int'(ovf_err), 1);
      tick();
      chk("R3", "ovf sticky", int'(ovf_err), 1);
   endtask

   task automatic t_handshake_retire();
      iso_mode = 1'b0; int_en = 1'b1;
      pulse(P_TOK);
      pulse(P_SENT);
      chk("R4", "busy after sent without ack", int'(busy_banks), 3);
      chk("R4", "txc after sent without ack", int'(tx_complete), 0);
      pulse(P_ACK);
      chk("R4", "busy after ack", int'(busy_banks), 2);
      chk("R6", "txc after ack", int'(tx_complete), 1);
      chk("R11", "irq on status fall", int'(irq), 1);
      tick();
      chk("R11", "irq single cycle", int'(irq), 0);
      chk("R6", "txc held", int'(tx_complete), 1);
      pulse(P_TXC);
      chk("R6", "txc cleared by strobe", int'(tx_complete), 0);
      pulse(P_ACK);
      chk("R4", "ack without token ignored", int'(busy_banks), 2);
   endtask

   task automatic t_endpoint_reset();
      pulse(P_RST);
      chk("R1", "busy after endpoint reset", int'(busy_banks), 0);
      chk("R1", "ovf after endpoint reset", int'(ovf_err), 0);
   endtask

   task automatic t_iso_retire();
      iso_mode = 1'b1; int_en = 1'b0;
      pulse(P_FILL); pulse(P_FILL); pulse(P_FILL);
      pulse(P_TOK);
      pulse(P_SENT);
      chk("R5", "iso busy after sent", int'(busy_banks), 2);
      chk("R6", "iso txc after sent", int'(tx_complete), 1);
      chk("R11", "irq gated by enable", int'(irq), 0);
      pulse(P_TXC);
   endtask

   task automatic t_kill_idle();
      pulse(P_KILL);
      chk("R7", "pending after kill", int'(kill_pending), 1);
      chk("R7", "busy before resolve", int'(busy_banks), 2);
      tick();
      chk("R7", "busy after drop", int'(busy_banks), 1);
      chk("R7", "pending after drop", int'(kill_pending), 0);
      int_en = 1'b1;
      pulse(P_FILL); pulse(P_FILL);
      pulse(P_KILL);
      tick();
      chk("R11", "irq on kill from full", int'(irq), 1);
      chk("R7", "busy after drop from full", int'(busy_banks), 2);
      tick();
      pulse(P_DIS);
      chk("R1", "busy after disable", int'(busy_banks), 0);
   endtask

   task automatic t_kill_refused();
      iso_mode = 1'b0;
      pulse(P_FILL);
      pulse(P_KILL);
      pulse(P_TOK);
      chk("R8", "pending held during single transfer", int'(kill_pending), 1);
      chk("R8", "bank kept", int'(busy_banks), 1);
      pulse(P_KILL);
      chk("R8", "second kill ignored", int'(busy_banks), 1);
      pulse(P_ACK);
      chk("R8", "bank sent instead", int'(busy_banks), 0);
      chk("R8", "txc after refused kill", int'(tx_complete), 1);
      chk("R8", "pending until next cycle", int'(kill_pending), 1);
      tick();
      chk("R8", "pending cleared after send", int'(kill_pending), 0);
      pulse(P_TXC);
   endtask

   task automatic t_kill_retarget();
      pulse(P_FILL); pulse(P_FILL);
      pulse(P_KILL);
      pulse(P_TOK);
      chk("R9", "newest bank dropped", int'(busy_banks), 1);
      chk("R9", "pending cleared", int'(kill_pending), 0);
      pulse(P_ACK);
      chk("R9", "current bank still retires", int'(busy_banks), 0);
      chk("R9", "txc after retire", int'(tx_complete), 1);
   endtask

   task automatic t_kill_empty();
      pulse(P_KILL);
      chk("R10", "pending on empty", int'(kill_pending), 1);
      tick();
      chk("R10", "pending resolves", int'(kill_pending), 0);
      chk("R10", "busy unchanged", int'(busy_banks), 0);
   endtask

   task automatic t_disable_pending();
      pulse(P_FILL);
      pulse(P_KILL);
      pulse(P_TOK);
      pulse(P_DIS);
      chk("R1", "pending cleared by disable", int'(kill_pending), 0);
      chk("R1", "busy cleared by disable", int'(busy_banks), 0);
      chk("R1", "txc cleared by disable", int'(tx_complete), 0);
      pulse(P_ACK);
      chk("R1", "no retire after disable", int'(tx_complete), 0);
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset_state();
      t_fill_and_overflow();
      t_handshake_retire();
      t_endpoint_reset();
      t_iso_retire();
      t_kill_idle();
      t_kill_refused();
      t_kill_retarget();
      t_kill_empty();
      t_disable_pending();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule